// File: doc/BRIEF.md
# Four-bit eight-function arithmetic/logic unit

A purely combinational arithmetic/logic unit. It takes two 4-bit operands and a 3-bit function code. Four codes select arithmetic:

- sum
- increment
- difference
- decrement

The other four select bitwise logic:

- exclusive-or
- complement of the first operand
- inclusive-or
- and

The result wraps modulo 16. A carry output comes from the underlying two's-complement addition. For the subtracting codes that carry means "no borrow".

Two status outputs are also provided:

- A signed-overflow flag, which treats the operands as two's-complement numbers.
- A zero flag on the 4-bit result.

The unit holds no state. A surrounding datapath registers its outputs as it sees fit. The width is a parameter (4 by default, at least 2), while the code map is fixed.

Top module: `nibble_alu`

## Requirements
- R1: Code 3'b000 gives res = (opa + opb) mod 16, and cout equals bit 4 of the 5-bit sum.
- R2: Code 3'b001 gives res = (opa + 1) mod 16, and cout = 1 exactly when opa = 4'hF.
- R3: Code 3'b010 gives res = (opa - opb) mod 16, and cout = 1 exactly when opa >= opb (unsigned, no borrow).
- R4: Code 3'b011 gives res = (opa - 1) mod 16, and cout = 1 exactly when opa != 0.
- R5: Code 3'b100 gives res = opa XOR opb. Code 3'b101 gives res = NOT opa.
- R6: Code 3'b110 gives res = opa OR opb. Code 3'b111 gives res = opa AND opb.
- R7: For every code with bit 2 set (the logic codes), cout = 0 and ovf = 0.
- R8: For codes 3'b000 to 3'b011, ovf = 1 exactly when the true signed result, with opa and opb read as two's-complement values, falls outside -8..7.
- R9: zero = 1 exactly when res = 0, for every code.
- R10: For codes 3'b001, 3'b011 and 3'b101, all outputs are independent of opb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand |
| opsel | input | 3 | Function code |
| res | output | 4 | Result, modulo 16 |
| cout | output | 1 | Carry of the arithmetic codes, 0 for logic codes |
| ovf | output | 1 | Signed overflow of the arithmetic codes, 0 for logic codes |
| zero | output | 1 | Result equals zero |

## Verification
Carry, signed overflow and the zero flag are three separate outputs, yet one input pattern can raise all of them in the same evaluation. Adding 8 to 8 produces a zero result, a carry out and a signed overflow together. Subtracting equal operands gives zero together with carry set. The bench drives these coincidences from its vector table and compares every flag at once against hand-derived values. It then sweeps all 2048 code and operand combinations against a reference computed from integer arithmetic.

// File: rtl/nibble_alu_pkg.sv
package nibble_alu_pkg;

  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_INC  = 3'b001,
    FN_SUB  = 3'b010,
    FN_DEC  = 3'b011,
    FN_XOR  = 3'b100,
    FN_NOTA = 3'b101,
    FN_OR   = 3'b110,
    FN_AND  = 3'b111
  } alu_fn_e;

  localparam int unsigned FN_W = 3;

endpackage

// File: rtl/nibble_alu_arith.sv
module nibble_alu_arith #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             unary,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             sovf
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] b_sel;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   chain;

  always_comb begin
    b_sel = unary ? ONE : b_in;
    b_eff = b_sel ^ {WIDTH{subtract}};
  end

  assign chain[0] = subtract;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]     = a_in[i] ^ b_eff[i] ^ chain[i];
    assign chain[i+1] = (a_in[i] & b_eff[i]) | (chain[i] & (a_in[i] ^ b_eff[i]));
  end

  assign carry = chain[WIDTH];
  assign sovf  = chain[WIDTH] ^ chain[WIDTH-1];

endmodule

// File: rtl/nibble_alu_logic.sv
module nibble_alu_logic #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [1:0]       fsel,
  output logic [WIDTH-1:0] bits
);

  always_comb begin
    unique case (fsel)
      2'b00:   bits = a_in ^ b_in;
      2'b01:   bits = ~a_in;
      2'b10:   bits = a_in | b_in;
      default: bits = a_in & b_in;
    endcase
  end

endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import nibble_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [FN_W-1:0]  opsel,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             ovf,
  output logic             zero
);

  logic [WIDTH-1:0] arith_sum;
  logic             arith_c;
  logic             arith_v;
  logic [WIDTH-1:0] logic_bits;
  logic             is_logic;

  assign is_logic = opsel[2];

  nibble_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_in     (opa),
    .b_in     (opb),
    .unary    (opsel[0]),
    .subtract (opsel[1]),
    .sum      (arith_sum),
    .carry    (arith_c),
    .sovf     (arith_v)
  );

  nibble_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_in (opa),
    .b_in (opb),
    .fsel (opsel[1:0]),
    .bits (logic_bits)
  );

  always_comb begin
    res  = is_logic ? logic_bits : arith_sum;
    cout = arith_c & ~is_logic;
    ovf  = arith_v & ~is_logic;
    zero = ~|res;
  end

endmodule

// File: rtl/nibble_alu_chk.sv
module nibble_alu_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [2:0]       opsel,
  input logic [WIDTH-1:0] res,
  input logic             cout,
  input logic             ovf,
  input logic             zero
);

  localparam int MODV = 1 << WIDTH;

  int ua, ub, ur;

  always_comb begin
    ua = int'(opa);
    ub = int'(opb);
    ur = int'(res);
    if (opsel == 3'b000) begin
      assert_add_R1: assert (ur + (cout ? MODV : 0) == ua + ub)
        else $error("add mismatch");
    end
    if (opsel == 3'b001) begin
      assert_inc_R2: assert (ur == (ua + 1) % MODV && cout == (ua == MODV - 1))
        else $error("inc mismatch");
    end
    if (opsel == 3'b010) begin
      assert_sub_R3: assert (ur == (ua - ub + MODV) % MODV && cout == (ua >= ub))
        else $error("sub mismatch");
    end
    if (opsel == 3'b011) begin
      assert_dec_R4: assert (ur == (ua + MODV - 1) % MODV && cout == (ua != 0))
        else $error("dec mismatch");
    end
    if (opsel[2]) begin
      assert_logic_flags_R7: assert (!cout && !ovf)
        else $error("logic flags set");
    end
    assert_zero_flag_R9: assert (zero == (res == '0))
      else $error("zero flag wrong");
  end

endmodule

bind nibble_alu nibble_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa   (opa),
  .opb   (opb),
  .opsel (opsel),
  .res   (res),
  .cout  (cout),
  .ovf   (ovf),
  .zero  (zero)
);

// File: tb/nibble_alu_test.sv
module nibble_alu_test;

  logic       clk;
  logic       rst_n;
  logic [3:0] opa, opb;
  logic [2:0] opsel;
  logic [3:0] res;
  logic       cout, ovf, zero;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  nibble_alu uut (
    .opa(opa), .opb(opb), .opsel(opsel),
    .res(res), .cout(cout), .ovf(ovf), .zero(zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: {code, a, b, res, cout, ovf, zero}
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {3'd0, 4'h7, 4'h9, 4'h0, 1'b1, 1'b0, 1'b1},
    {3'd0, 4'h8, 4'h8, 4'h0, 1'b1, 1'b1, 1'b1},
    {3'd0, 4'h5, 4'h6, 4'hB, 1'b0, 1'b1, 1'b0},
    {3'd1, 4'hF, 4'h3, 4'h0, 1'b1, 1'b0, 1'b1},
    {3'd1, 4'h7, 4'h0, 4'h8, 1'b0, 1'b1, 1'b0},
    {3'd2, 4'h5, 4'h5, 4'h0, 1'b1, 1'b0, 1'b1},
    {3'd2, 4'h3, 4'h5, 4'hE, 1'b0, 1'b0, 1'b0},
    {3'd2, 4'h8, 4'h1, 4'h7, 1'b1, 1'b1, 1'b0},
    {3'd3, 4'h0, 4'hA, 4'hF, 1'b0, 1'b0, 1'b0},
    {3'd3, 4'h8, 4'h2, 4'h7, 1'b1, 1'b1, 1'b0},
    {3'd4, 4'hC, 4'hA, 4'h6, 1'b0, 1'b0, 1'b0},
    {3'd5, 4'h5, 4'hF, 4'hA, 1'b0, 1'b0, 1'b0},
    {3'd6, 4'h5, 4'hA, 4'hF, 1'b0, 1'b0, 1'b0},
    {3'd7, 4'hC, 4'hA, 4'h8, 1'b0, 1'b0, 1'b0},
    {3'd7, 4'h5, 4'hA, 4'h0, 1'b0, 1'b0, 1'b1}
  };

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R1/R8/R9";
      3'd1: return "R2/R8/R9";
      3'd2: return "R3/R8/R9";
      3'd3: return "R4/R8/R9";
      3'd4, 3'd5: return "R5/R7/R9";
      default: return "R6/R7/R9";
    endcase
  endfunction

  // reference from the requirements: {res, cout, ovf, zero}
  function automatic logic [6:0] model(input logic [2:0] c, input logic [3:0] a, input logic [3:0] b);
    int ua, ub, full, sa, sb, s;
    logic [3:0] y;
    logic cy, v;
    ua = int'(a); ub = int'(b);
    sa = (ua >= 8) ? ua - 16 : ua;
    sb = (ub >= 8) ? ub - 16 : ub;
    full = 0; s = 0; cy = 1'b0; v = 1'b0; y = 4'h0;
    case (c)
      3'd0: begin full = ua + ub;      s = sa + sb; end
      3'd1: begin full = ua + 1;       s = sa + 1;  end
      3'd2: begin full = ua + 16 - ub; s = sa - sb; end
      3'd3: begin full = ua + 15;      s = sa - 1;  end
      default: ;
    endcase
    if (!c[2]) begin
      y  = 4'(full % 16);
      cy = (full >= 16);
      v  = (s > 7) || (s < -8);
    end else begin
      case (c[1:0])
        2'd0: y = a ^ b;
        2'd1: y = ~a;
        2'd2: y = a | b;
        default: y = a & b;
      endcase
    end
    return {y, cy, v, (y == 4'h0)};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s code=%0d a=%h b=%h actual{res,c,v,z}=%h/%b%b%b expected=%h/%b%b%b",
               req, opsel, opa, opb, act[6:3], act[2], act[1], act[0],
               exp[6:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    opsel = c; opa = a; opb = b;
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    opsel = 3'd0; opa = 4'h0; opb = 4'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // initial state: all-zero inputs -> zero result, zero flag only (R9)
    check("R9 idle", {res, cout, ovf, zero}, 7'b0000_001);

    // hand-derived vector table, includes coinciding flags
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][17:15], VEC[i][14:11], VEC[i][10:7]);
      check({req_of(VEC[i][17:15]), " table"}, {res, cout, ovf, zero}, VEC[i][6:0]);
    end

    // exhaustive sweep against the integer reference
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          apply(3'(c), 4'(a), 4'(b));
          check(req_of(3'(c)), {res, cout, ovf, zero}, model(3'(c), 4'(a), 4'(b)));
        end
      end
    end

    // R10: unary codes ignore opb
    for (int k = 0; k < 3; k++) begin
      logic [2:0] uc;
      uc = (k == 0) ? 3'd1 : (k == 1) ? 3'd3 : 3'd5;
      for (int a = 0; a < 16; a += 5) begin
        logic [6:0] base;
        apply(uc, 4'(a), 4'h0);
        base = {res, cout, ovf, zero};
        for (int b = 1; b < 16; b += 3) begin
          apply(uc, 4'(a), 4'(b));
          check("R10 unary ignores opb", {res, cout, ovf, zero}, base);
        end
      end
    end

    // corner: carry boundary for increment and decrement
    apply(3'd1, 4'hE, 4'hF);
    check("R2 below wrap", {res, cout, ovf, zero}, 7'b1111_000);
    apply(3'd3, 4'h1, 4'h0);
    check("R4 to zero", {res, cout, ovf, zero}, 7'b0000_101);
    apply(3'd2, 4'h0, 4'hF);
    check("R3 borrow", {res, cout, ovf, zero}, 7'b0001_000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule